// File: doc/BRIEF.md
# Public Data Input Segment Parser

This block sits between a 32-bit public data input stream and the datapath of an authenticated cipher. The stream carries an instruction word and then a chain of segment headers. Each header is followed by its data words. The parser consumes the instruction and header words itself. It forwards each data word to the datapath with sideband fields that tell the datapath what the word is: the current operation, the segment type, how many leading bytes of the word are real, and whether this is the final word of the segment. On that final word it also reports the header's last-of-type and last-of-input flags.

A segment that carries no bytes is still reported to the datapath. It appears as a single marker beat with a byte count of zero, and it consumes nothing from the input. A key-activation instruction is reported the same way, as one marker beat. Reserved opcodes are swallowed silently. Data words pass straight through under valid/ready flow control with no buffering. The block does not validate the format of the stream.

Top module: `pdi_seg_parser`

## Requirements
- R1: After a synchronous active-low reset, the block waits for an instruction word: `in_ready` is 1 and `out_valid` is 0.
- R2: An instruction word whose bits 31:28 are 0010 selects encryption (`out_op` = 1), and 0011 selects decryption (`out_op` = 2). Segment headers follow such an instruction. An instruction word produces no output beat.
- R3: An instruction word whose bits 31:28 are 0111 produces exactly one marker beat with `out_op` = 3, `out_type` = 0, `out_bytes` = 0, `out_eot` = 0, `out_eoi` = 1 and data 0. The block then waits for a new instruction word.
- R4: An instruction word with any other opcode is consumed and ignored. No output beat follows it, and the next word is again treated as an instruction.
- R5: A header word carries the type in bits 31:28, EOI in bit 27, EOT in bit 25 and the byte length in bits 15:0. The type is forwarded unchanged on `out_type`. A header word produces no output beat.
- R6: During a segment's data phase, `out_valid` follows `in_valid` and `in_ready` follows `out_ready`. A word moves only in a cycle where both are high.
- R7: A segment of L > 0 bytes yields ceil(L/4) data beats. Each beat's `out_bytes` is the smaller of 4 and the number of bytes still remaining.
- R8: Bytes are big-endian: the first byte is bits 31:24. Bytes beyond `out_bytes` are forced to zero on `out_data`, whatever the input held.
- R9: `out_eot` and `out_eoi` copy the header's EOT and EOI on the final beat of a segment and are 0 on every other beat.
- R10: A segment with length 0 produces one marker beat with `out_bytes` = 0 and data 0. The marker carries the header's type, EOT and EOI, and no input word is consumed during it.
- R11: After the final beat of a segment whose EOI is 1, the next input word is decoded as an instruction. Otherwise the next input word is decoded as a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | 32 | Public input word |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Datapath accepts the beat |
| out_data | output | 32 | Data word with unused bytes cleared |
| out_op | output | 2 | 1 encrypt, 2 decrypt, 3 key activation |
| out_type | output | 4 | Segment type from the header |
| out_bytes | output | 3 | Valid leading bytes, 0 for a marker beat |
| out_eot | output | 1 | Last segment of its type, on the final beat |
| out_eoi | output | 1 | Last segment of the input, on the final beat |

## Verification
Two events can land in the same handshake. The final, partial word of a segment whose EOI is set carries both its byte count and the flags. That same word also sends the block back to instruction decoding, and the next word is already waiting. The bench provokes this with segment lengths that are not multiples of four, followed at once by a fresh instruction. It runs these under random stalls on both sides, and with a zero-length final segment. A behavioural model predicts every beat, and any beat that appears where a header or instruction was due is reported as a mismatch.

// File: rtl/pdi_seg_parser.sv
module pdi_seg_parser (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] in_data,
  input  logic        in_valid,
  output logic        in_ready,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic [1:0]  out_op,
  output logic [3:0]  out_type,
  output logic [2:0]  out_bytes,
  output logic        out_eot,
  output logic        out_eoi
);

  typedef enum logic [2:0] {S_INSTR, S_HDR, S_DATA, S_EMPTY, S_KEY} st_t;

  st_t         st;
  logic [1:0]  op_q;
  logic [3:0]  type_q;
  logic        eot_q, eoi_q;
  logic [15:0] rem_q;

  logic        last_w, fin_w, take, give;
  logic [2:0]  bytes_w;
  logic [31:0] masked;

  assign last_w  = rem_q <= 16'd4;
  assign bytes_w = last_w ? rem_q[2:0] : 3'd4;
  assign fin_w   = (st == S_DATA && last_w) || st == S_EMPTY;

  always_comb begin
    masked = in_data;
    for (int i = 0; i < 4; i++)
      if (3'(i) >= bytes_w) masked[31-8*i -: 8] = 8'h00;
  end

  assign in_ready  = st == S_INSTR || st == S_HDR || (st == S_DATA && out_ready);
  assign out_valid = (st == S_DATA && in_valid) || st == S_EMPTY || st == S_KEY;
  assign out_op    = (st == S_KEY) ? 2'd3 : op_q;
  assign out_type  = (st == S_KEY) ? 4'd0 : type_q;
  assign out_bytes = (st == S_DATA) ? bytes_w : 3'd0;
  assign out_data  = (st == S_DATA) ? masked : 32'h0;
  assign out_eot   = fin_w && eot_q;
  assign out_eoi   = st == S_KEY || (fin_w && eoi_q);

  assign take = in_valid && in_ready;
  assign give = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_INSTR;
      op_q   <= 2'd0;
      type_q <= 4'd0;
      eot_q  <= 1'b0;
      eoi_q  <= 1'b0;
      rem_q  <= 16'd0;
    end else begin
      case (st)
        S_INSTR: if (take) begin
          case (in_data[31:28])
            4'b0010: begin op_q <= 2'd1; st <= S_HDR; end
            4'b0011: begin op_q <= 2'd2; st <= S_HDR; end
            4'b0111: st <= S_KEY;
            default: st <= S_INSTR;
          endcase
        end
        S_HDR: if (take) begin
          type_q <= in_data[31:28];
          eoi_q  <= in_data[27];
          eot_q  <= in_data[25];
          rem_q  <= in_data[15:0];
          st     <= (in_data[15:0] == 16'd0) ? S_EMPTY : S_DATA;
        end
        S_DATA: if (give) begin
          if (last_w) st <= eoi_q ? S_INSTR : S_HDR;
          else        rem_q <= rem_q - 16'd4;
        end
        S_EMPTY: if (give) st <= eoi_q ? S_INSTR : S_HDR;
        S_KEY:   if (give) st <= S_INSTR;
        default: st <= S_INSTR;
      endcase
    end
  end

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> in_ready && !out_valid);

  a_r6_word_needs_sink: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && out_valid |-> out_ready);

  a_r7_bytes_bound: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_bytes <= 3'd4);

  a_r8_single_byte_clear: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_bytes == 3'd1 |-> out_data[23:0] == 24'h0);

  a_r10_marker_takes_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_bytes == 3'd0 |-> !in_ready && out_data == 32'h0);

  a_r11_back_to_instr: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_eoi |=> in_ready && !out_valid);

endmodule

// File: tb/pdi_seg_parser_test.sv
`timescale 1ns/1ps
module pdi_seg_parser_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] in_data = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 0;
  logic [31:0] out_data;
  logic [1:0]  out_op;
  logic [3:0]  out_type;
  logic [2:0]  out_bytes;
  logic        out_eot, out_eoi;

  always #2.5 clk = ~clk;

  pdi_seg_parser uut (.*);

  int total = 0, fails = 0;
  logic [31:0] inq[$];
  logic [42:0] expq[$];
  logic [1:0]  cur_op = 0;
  logic [7:0]  lf = 8'h5a;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mask_w(input logic [31:0] w, input int n);
    logic [31:0] r = w;
    for (int i = 0; i < 4; i++) if (i >= n) r[31-8*i -: 8] = 8'h00;
    return r;
  endfunction

  task automatic instr(input logic [3:0] code);
    inq.push_back({code, 28'h0});
    if (code == 4'b0010) cur_op = 2'd1;
    else if (code == 4'b0011) cur_op = 2'd2;
    else if (code == 4'b0111) expq.push_back({2'd3, 4'd0, 3'd0, 1'b0, 1'b1, 32'h0});
  endtask

  task automatic seg(input logic [3:0] ty, input bit eot, input bit eoi, input int len);
    inq.push_back({ty, eoi, 1'b0, eot, 1'b0, 8'h00, 16'(len)});
    if (len == 0) expq.push_back({cur_op, ty, 3'd0, eot, eoi, 32'h0});
    for (int w = 0; w * 4 < len; w++) begin
      int n = (len - 4 * w >= 4) ? 4 : len - 4 * w;
      bit fin = (len - 4 * w) <= 4;
      logic [31:0] raw = $urandom;
      inq.push_back(raw);
      expq.push_back({cur_op, ty, 3'(n), fin & eot, fin & eoi, mask_w(raw, n)});
    end
  endtask

  task automatic beat();
    logic [42:0] e;
    if (expq.size() == 0) begin
      chk(0, "R4 unexpected beat", out_data, 0);
      return;
    end
    e = expq.pop_front();
    chk(out_op == e[42:41], e[42:41] == 2'd3 ? "R3 op" : "R2 op", 32'(out_op), 32'(e[42:41]));
    chk(out_type == e[40:37], "R5 type", 32'(out_type), 32'(e[40:37]));
    chk(out_bytes == e[36:34], e[36:34] == 0 ? "R10 bytes" : "R7 bytes", 32'(out_bytes), 32'(e[36:34]));
    chk(out_data == e[31:0], "R8 data", out_data, e[31:0]);
    chk({out_eot, out_eoi} == e[33:32], "R9 flags", 32'({out_eot, out_eoi}), 32'(e[33:32]));
    if (e[36:34] == 0) chk(!in_ready, "R10 no input taken", 32'(in_ready), 0);
  endtask

  task automatic run(input int mode);
    int guard = 0;
    while ((inq.size() > 0 || expq.size() > 0) && guard < 20000) begin
      @(negedge clk);
      guard++;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      in_valid  = inq.size() > 0 && (mode == 0 || lf[0] || lf[3]);
      in_data   = (inq.size() > 0) ? inq[0] : 32'h0;
      out_ready = mode == 0 || lf[1] || lf[5];
      #1;
      if (out_valid && !out_ready && in_valid)
        chk(!in_ready, "R6 stall holds input", 32'(in_ready), 0);
      if (out_valid && out_ready) beat();
      if (in_valid && in_ready) void'(inq.pop_front());
    end
    if (guard >= 20000) chk(0, "watchdog", 32'(guard), 0);
    @(negedge clk);
    in_valid = 0;
    #1;
    chk(in_ready && !out_valid, "R11 idle at end", 32'({in_ready, out_valid}), 32'h2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(in_ready && !out_valid, "R1 reset state", 32'({in_ready, out_valid}), 32'h2);

    instr(4'b0111);
    instr(4'b0010);
    seg(4'b1100, 1, 0, 16);
    seg(4'b0001, 0, 0, 5);
    seg(4'b0001, 1, 0, 0);
    seg(4'b0100, 1, 1, 7);
    instr(4'b0101);
    instr(4'b0011);
    seg(4'b1100, 1, 0, 12);
    seg(4'b0001, 1, 0, 0);
    seg(4'b0101, 1, 0, 4);
    seg(4'b1101, 1, 1, 16);
    run(0);

    instr(4'b0000);
    instr(4'b0010);
    seg(4'b1100, 1, 0, 1);
    seg(4'b0001, 1, 0, 3);
    seg(4'b0100, 1, 1, 0);
    instr(4'b0011);
    seg(4'b0101, 0, 0, 8);
    seg(4'b0101, 0, 0, 2);
    seg(4'b0101, 1, 0, 6);
    seg(4'b1101, 1, 1, 13);
    instr(4'b0111);
    instr(4'b0010);
    seg(4'b0010, 1, 0, 9);
    seg(4'b0100, 1, 1, 11);
    run(1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule